// File: doc/BRIEF.md
# Microwire Serial EEPROM Word Access Engine

The engine reads and writes 16-bit words in a small serial EEPROM with six-bit word addresses, over a four-wire link. The four wires are a chip select, a shift clock, a data line toward the memory and a data line back from it. The host presents a word address, picks a read or a write, and pulses `start` for one cycle. The engine then produces the complete serial exchange on its own. When the exchange has finished and the link lines are back at rest, it raises `done` for one cycle.

A read sends an eleven-bit command and then clocks sixteen data bits back. The first bit received becomes the least significant bit of the result. A write first sends the enable-write command and then pulses the clock once with chip select low. Next it sends the write command with the address, and then the sixteen data bits, least significant bit first. After one more clock pulse with chip select low, it raises chip select again and watches the returned data line until the memory reports that it is ready. This busy poll has a bounded length. If the memory never reports ready, the access is closed normally and an error flag is raised.

The serial clock rate is set by a parameter that gives the length of each clock half in system cycles.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: A read sends 11 bits on `mw_di`, most significant first, with `mw_cs` high throughout: binary 00 110 followed by the address bits a5..a0. Each bit is placed while `mw_sk` is low and is held unchanged while `mw_sk` is high.
- R2: After the read command, the engine gives 16 clock pulses. The bit seen on `mw_do` during pulse i (counting from 0) ends up in `rdata[i]`, so the first bit received is the least significant bit.
- R3: `mw_do` is sampled at the end of the high half of each data pulse. The engine then drives `mw_sk` low before the next pulse begins.
- R4: Every access ends with `mw_cs` high alone and `mw_sk` low for one clock half. Then all three link outputs go to 0. `done` pulses high for one cycle exactly one clock half after `mw_cs` falls, and `busy` is low from that cycle on. While the engine is idle, all three link outputs are 0.
- R5: A write (`write`=1) first sends the 10-bit word 0100110000 with `mw_cs` high. It then gives one clock pulse with `mw_cs` low and `mw_di` low. Next it sends the 10 bits 0101 followed by a5..a0, and then the 16 bits of `wdata`, least significant first, all with `mw_cs` high.
- R6: After the write data, the engine gives one clock pulse with `mw_cs` low. It then holds `mw_cs` high and `mw_sk` low and polls `mw_do` once per clock half, until `mw_do` reads 1. The access then ends as in R4 with `err` low.
- R7: If `mw_do` stays 0 for POLL_LIMIT polls, the engine sets `err` and ends the access as in R4. `err` stays set until the next accepted start, which clears it.
- R8: A `start` pulse while `busy` is high is ignored: the access in progress continues unchanged and no second access follows. `busy` rises on the cycle after an accepted start.
- R9: Each high half of the shift clock lasts exactly HALF_DIV system cycles.
- R10: After reset, `busy`, `done` and `err` are 0, and all link outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an access |
| write | input | 1 | 1 selects a word write, 0 a word read; sampled with start |
| addr | input | 6 | Word address; sampled with start |
| wdata | input | 16 | Word to write; sampled with start |
| rdata | output | 16 | Last word read |
| done | output | 1 | One-cycle pulse at the end of an access |
| busy | output | 1 | High while an access is in progress |
| err | output | 1 | Write-ready poll timed out |
| mw_cs | output | 1 | Chip select to the EEPROM |
| mw_sk | output | 1 | Shift clock to the EEPROM |
| mw_di | output | 1 | Serial data to the EEPROM |
| mw_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest condition to reach is the end of the write-ready poll: the engine must leave the poll on the memory's signal or on its own time limit, and both must close the link cleanly. To reach it, the bench counts shift-clock edges until all 38 write edges have been seen. It then holds the returned data line low for a chosen number of cycles before raising it. In one scenario it never raises the line, and the poll limit is shortened through a parameter so that the timeout path is taken quickly. A further scenario pulses `start` in the middle of a read and then confirms that the edge count and the command bits remain those of the first request.

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl #(
  parameter int HALF_DIV   = 63,
  parameter int POLL_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        write,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        done,
  output logic        busy,
  output logic        err,
  output logic        mw_cs,
  output logic        mw_sk,
  output logic        mw_di,
  input  logic        mw_do
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int TW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_RPRE, S_RD, S_GAP, S_WDAT, S_POLL, S_END1, S_END2
  } st_t;

  st_t          st;
  logic [DW-1:0] div;
  logic [TW-1:0] tcnt;
  logic         ph, is_wr, second;
  logic [3:0]   cnt;
  logic [15:0]  sh, rd_q, wd_q;
  logic [5:0]   addr_q;
  logic         tick;

  assign tick  = (st != S_IDLE) && (div == DW'(HALF_DIV - 1));
  assign busy  = (st != S_IDLE);
  assign rdata = rd_q;
  assign mw_cs = st inside {S_CMD, S_RPRE, S_RD, S_WDAT, S_POLL, S_END1};
  assign mw_sk = ph && (st inside {S_CMD, S_RD, S_GAP, S_WDAT});
  assign mw_di = (st == S_CMD) ? sh[15] : (st == S_WDAT) ? sh[0] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; tcnt <= '0; ph <= 1'b0; is_wr <= 1'b0;
      second <= 1'b0; cnt <= '0; sh <= '0; rd_q <= '0; wd_q <= '0;
      addr_q <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        div <= '0;
        if (start) begin
          st <= S_CMD; ph <= 1'b0; cnt <= '0; second <= 1'b0;
          is_wr <= write; err <= 1'b0; addr_q <= addr; wd_q <= wdata;
          sh <= write ? {10'b0100110000, 6'b0} : {5'b00110, addr, 5'b0};
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          case (st)
            S_CMD, S_WDAT: begin
              if (!ph) ph <= 1'b1;
              else begin
                ph  <= 1'b0;
                cnt <= cnt + 1'b1;
                sh  <= (st == S_CMD) ? (sh << 1) : (sh >> 1);
                if (st == S_WDAT && cnt == 4'd15) begin
                  st <= S_GAP; cnt <= '0;
                end else if (st == S_CMD && cnt == (is_wr ? 4'd9 : 4'd10)) begin
                  cnt <= '0;
                  if (!is_wr) st <= S_RPRE;
                  else if (!second) st <= S_GAP;
                  else begin st <= S_WDAT; sh <= wd_q; end
                end
              end
            end
            S_RPRE: begin st <= S_RD; ph <= 1'b1; end
            S_RD: begin
              if (ph) begin
                rd_q <= {mw_do, rd_q[15:1]};
                ph   <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
                if (cnt == 4'd15) st <= S_END1;
                else ph <= 1'b1;
              end
            end
            S_GAP: begin
              if (!ph) ph <= 1'b1;
              else begin
                ph <= 1'b0;
                if (!second) begin
                  second <= 1'b1; st <= S_CMD; cnt <= '0;
                  sh <= {4'b0101, addr_q, 6'b0};
                end else begin
                  st <= S_POLL; tcnt <= '0;
                end
              end
            end
            S_POLL: begin
              if (mw_do) st <= S_END1;
              else if (tcnt == TW'(POLL_LIMIT - 1)) begin
                err <= 1'b1; st <= S_END1;
              end else tcnt <= tcnt + 1'b1;
            end
            S_END1: st <= S_END2;
            S_END2: begin st <= S_IDLE; done <= 1'b1; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic busy,
  input logic err,
  input logic mw_cs,
  input logic mw_sk,
  input logic mw_di
);
  assert_di_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_di));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mw_cs && !mw_sk && !mw_di));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err);

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .err(err), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di)
);

// File: tb/mw_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_tb_top;
  localparam int HALF = 4;
  localparam int PLIM = 24;

  logic clk = 0, rst_n = 0, start = 0, write = 0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic done, busy, err, mw_cs, mw_sk, mw_di, mw_do;
  logic rd_mode = 0, rd_bit = 0, ready = 0;
  logic [15:0] rd_word = '0;
  int edge_n = 0, base = 0, cyc = 0, total = 0, bad = 0;
  logic log_cs [0:511];
  logic log_di [0:511];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mw_do = rd_mode ? rd_bit : ready;

  always @(posedge mw_sk) begin
    log_cs[edge_n[8:0]] <= mw_cs;
    log_di[edge_n[8:0]] <= mw_di;
    if (rd_mode && (edge_n - base) >= 11 && (edge_n - base) < 27)
      rd_bit <= #1 rd_word[edge_n - base - 11];
    edge_n <= edge_n + 1;
  end

  mw_eeprom_ctrl #(.HALF_DIV(HALF), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .write(write), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .busy(busy), .err(err),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(0, {tag, " watchdog"}, 0, 1);
  endtask

  task automatic kick(input logic w, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    write = w; addr = a; wdata = d; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R8 busy after start", busy, 1);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R10 busy", busy, 0);
    chk(done == 0, "R10 done", done, 0);
    chk(err == 0, "R10 err", err, 0);
    chk({mw_cs, mw_sk, mw_di} == 3'b000, "R10 lines", {mw_cs, mw_sk, mw_di}, 0);
  endtask

  task automatic t_read(input logic [5:0] a, input logic [15:0] w, input bit poke);
    logic [10:0] cmd;
    int hi = 0, t0, n;
    rd_mode = 1; rd_word = w; base = edge_n;
    kick(0, a, 16'h0);
    n = 0;
    while (!mw_sk && n < 1000) begin @(negedge clk); n++; end
    while (mw_sk && hi < 1000) begin hi++; @(negedge clk); end
    chk(hi == HALF, "R9 high half length", hi, HALF);
    if (poke) begin
      @(negedge clk); write = 1; addr = ~a; start = 1;
      @(negedge clk); start = 0;
    end
    n = 0;
    while (!(mw_cs && !mw_sk && (edge_n - base) >= 27) && n < 5000) begin @(negedge clk); n++; end
    while (mw_cs && n < 5000) begin @(negedge clk); n++; end
    t0 = cyc;
    wait_done("R4 read");
    chk(cyc - t0 == HALF, "R4 done one half after cs fall", cyc - t0, HALF);
    for (int i = 0; i < 11; i++) cmd[10-i] = log_di[(base+i) % 512];
    chk(cmd == {5'b00110, a}, "R1 read command bits", cmd, {5'b00110, a});
    chk(log_cs[base % 512] && log_cs[(base+26) % 512], "R1 cs high on pulses", 0, 1);
    chk(rdata == w, "R2 R3 read data LSB first", rdata, w);
    @(negedge clk);
    chk(busy == 0 && {mw_cs, mw_sk, mw_di} == 0, "R4 idle after done", {busy, mw_cs, mw_sk, mw_di}, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(edge_n - base == 27, "R8 no second access", edge_n - base, 27);
      chk(busy == 0, "R8 stays idle", busy, 0);
    end
    rd_mode = 0;
  endtask

  task automatic t_write(input logic [5:0] a, input logic [15:0] d, input bit give_ready);
    logic [9:0] v;
    logic [15:0] dv;
    int n = 0;
    rd_mode = 0; ready = 0; base = edge_n;
    kick(1, a, d);
    while ((edge_n - base) < 38 && n < 5000) begin @(negedge clk); n++; end
    if (give_ready) begin
      repeat (3 * HALF) @(negedge clk);
      chk(busy == 1 && mw_cs == 1 && mw_sk == 0, "R6 polling with cs high", {busy, mw_cs, mw_sk}, 3'b110);
      ready = 1;
    end
    wait_done("R6 write");
    ready = 0;
    for (int i = 0; i < 10; i++) v[9-i] = log_di[(base+i) % 512];
    chk(v == 10'b0100110000, "R5 write-enable bits", v, 10'b0100110000);
    chk(log_cs[(base+10) % 512] == 0 && log_di[(base+10) % 512] == 0, "R5 gap pulse cs low", log_cs[(base+10) % 512], 0);
    for (int i = 0; i < 10; i++) v[9-i] = log_di[(base+11+i) % 512];
    chk(v == {4'b0101, a}, "R5 write command bits", v, {4'b0101, a});
    for (int i = 0; i < 16; i++) dv[i] = log_di[(base+21+i) % 512];
    chk(dv == d, "R5 write data LSB first", dv, d);
    chk(log_cs[(base+37) % 512] == 0, "R6 cs low pulse after data", log_cs[(base+37) % 512], 0);
    chk(edge_n - base == 38, "R6 no clock during poll", edge_n - base, 38);
    if (give_ready) chk(err == 0, "R6 err low on ready", err, 0);
    else chk(err == 1, "R7 err on timeout", err, 1);
    @(negedge clk);
    chk(busy == 0 && {mw_cs, mw_sk, mw_di} == 0, "R4 R7 idle after write", {busy, mw_cs, mw_sk, mw_di}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(6'h05, 16'hA5C3, 0);
    t_read(6'h3F, 16'h8001, 0);
    t_read(6'h00, 16'h7FFE, 1);
    t_write(6'h2A, 16'h1234, 1);
    t_write(6'h15, 16'hF00F, 0);
    chk(err == 1, "R7 err held while idle", err, 1);
    t_read(6'h21, 16'h0F0F, 0);
    chk(err == 0, "R7 err cleared by next start", err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule